// File: doc/BRIEF.md
# Inverter Leg Gate Pulse Conditioner

This block turns the raw pulse-width-modulated bit for one half-bridge leg into the two gate drive signals for that leg. The upper-switch drive follows the conditioned bit and the lower-switch drive follows its complement. A minimum-width filter runs first. It removes any high or low excursion of the raw bit that is shorter than a programmable number of timing ticks, and it passes longer excursions with their width intact. After the filter, each drive has its turn-on delayed by a programmable underlap, so that both switches are off around every change of state.

The last stage is the output gate. An active-low enable input can silence both drives while the filter and delay stages keep running. A trip input forces both drives low at once and sets a latch that only a reset cycle can clear. All timing advances on a tick enable that runs at 512 times the carrier frequency. Both programmable times are given as inverted codes: an all-ones code is the shortest setting and an all-zeros code is the longest. Several instances of the block, one per leg, share the trip and reset inputs.

Top module: `leg_gate_conditioner`

## Requirements
- R1: While `rst_n` is low, `gate_hi` and `gate_lo` are low and `trip_ok` equals the inverse of `set_trip`. Reset returns the filter to the low level, so after release `gate_lo` comes up once the underlap has elapsed and `gate_hi` stays low.
- R2: The deletion length is pdt = 128 − `del_code` ticks (code 127 gives 1, code 0 gives 128). A high or low excursion of `pwm_raw` that lasts fewer than pdt consecutive ticks leaves both drives unchanged.
- R3: An excursion of `pwm_raw` that lasts at least pdt ticks is passed with the same width, delayed by pdt ticks. This holds at exactly pdt ticks.
- R4: The underlap is pdy = 64 − `dly_code` ticks (code 63 gives 1, code 0 gives 64). Each drive rises pdy ticks after its own condition becomes true and falls in the same cycle that the condition goes false. A filtered high of W ticks therefore gives a `gate_hi` pulse of W − pdy cycles and a `gate_lo` gap of W + pdy cycles.
- R5: `gate_hi` and `gate_lo` are never high in the same cycle.
- R6: While `drive_enable` is low, both drives are low in the same cycle. The filter and delay state keeps advancing, and when `drive_enable` returns high the drives show their current values at once.
- R7: While `set_trip` is high, both drives and `trip_ok` are low, with no clock needed.
- R8: Once `set_trip` has been high for the synchronizer depth, the trip state stays latched after `set_trip` falls, with both drives and `trip_ok` low, until `rst_n` goes low. On reset release `trip_ok` is high if `set_trip` is low, and the trip latches again if `set_trip` is still high.
- R9: When `tick_en` is low, neither the filter nor the underlap counters advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timing tick, one cycle wide, at 512 times the carrier frequency |
| pwm_raw | input | 1 | Raw modulated bit for this leg |
| del_code | input | DEL_W | Inverted minimum-width code |
| dly_code | input | DLY_W | Inverted underlap code |
| drive_enable | input | 1 | Output enable; low forces both drives low |
| set_trip | input | 1 | Asynchronous trip request, active high |
| gate_hi | output | 1 | Upper switch drive |
| gate_lo | output | 1 | Lower switch drive |
| trip_ok | output | 1 | High when not tripped |

## Verification
The filter is driven with the following stimuli:
- High pulses one tick shorter than the deletion length, exactly equal to it, and much longer than it. These separate a strict from an inclusive width comparison and show that width is preserved.
- A short low notch inside a long high level. This shows that deletion works on both polarities.
- The same long pulse with two different delay codes. This separates the underlap arithmetic from the filter latency.
- The extreme codes, one-tick deletion with one-tick delay. These expose off-by-one errors in the inverted code tables.

The gating is tried as follows:
- Inhibit is applied while a pulse is being formed. This shows whether the internal state keeps running behind the gate.
- The trip is raised and dropped, then cleared by reset, both with and without the trip input still high at reset release.
- A pulse is sent while the tick is held low, and again while the tick is thinned to every other cycle. These show whether the counters advance only on ticks.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
   parameter int unsigned GPC_DEL_W_DEF = 7;
   parameter int unsigned GPC_DLY_W_DEF = 6;
   parameter int unsigned GPC_SYNC_DEF  = 2;

   // which half of the leg a drive belongs to
   typedef enum logic {
      SW_HIGH = 1'b0,
      SW_LOW  = 1'b1
   } sw_side_e;
endpackage

// File: rtl/gpc_min_width_filter.sv
// Removes excursions of the raw bit shorter than (2**CODE_W - code) ticks.
module gpc_min_width_filter #(
   parameter int unsigned CODE_W = gpc_pkg::GPC_DEL_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              raw,
   input  logic [CODE_W-1:0] code,
   output logic              level
);
   localparam int unsigned CNT_W = CODE_W + 1;
   localparam logic [CNT_W-1:0] FULL    = {1'b1, {CODE_W{1'b0}}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{CODE_W{1'b0}}, 1'b1};

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nx;

   assign limit  = FULL - {1'b0, code};
   assign run_nx = run_q + CNT_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         run_q <= '0;
      end else if (tick) begin
         if (raw == level) begin
            run_q <= '0;
         end else if (run_nx >= limit) begin
            level <= raw;
            run_q <= '0;
         end else begin
            run_q <= run_nx;
         end
      end
   end
endmodule

// File: rtl/gpc_rise_delay.sv
// Holds off the rising edge of one drive by (2**CODE_W - code) ticks.
module gpc_rise_delay #(
   parameter int unsigned       CODE_W = gpc_pkg::GPC_DLY_W_DEF,
   parameter gpc_pkg::sw_side_e SIDE   = gpc_pkg::SW_HIGH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              level,
   input  logic [CODE_W-1:0] code,
   output logic              drive
);
   localparam int unsigned CNT_W = CODE_W + 1;
   localparam logic [CNT_W-1:0] FULL    = {1'b1, {CODE_W{1'b0}}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{CODE_W{1'b0}}, 1'b1};

   logic             follow;
   logic             armed_q;
   logic [CNT_W-1:0] wait_q;
   logic [CNT_W-1:0] wait_nx;
   logic [CNT_W-1:0] limit;

   if (SIDE == gpc_pkg::SW_HIGH) begin : g_upper
      assign follow = level;
   end else begin : g_lower
      assign follow = ~level;
   end

   assign limit   = FULL - {1'b0, code};
   assign wait_nx = wait_q + CNT_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         wait_q  <= '0;
      end else if (tick) begin
         if (!follow) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
         end else if (!armed_q) begin
            if (wait_nx >= limit) begin
               armed_q <= 1'b1;
               wait_q  <= '0;
            end else begin
               wait_q <= wait_nx;
            end
         end
      end
   end

   // falling edge is immediate, rising edge waits for the arm
   assign drive = armed_q & follow;
endmodule

// File: rtl/gpc_trip_latch.sv
// Sticky trip: combinational override plus a synchronized latch.
module gpc_trip_latch #(
   parameter int unsigned SYNC = gpc_pkg::GPC_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_trip,
   output logic tripped
);
   logic [SYNC-1:0] sync_q;
   logic            latched_q;

   for (genvar s = 0; s < SYNC; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= set_trip;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latched_q <= 1'b0;
      else if (sync_q[SYNC-1]) latched_q <= 1'b1;
   end

   assign tripped = latched_q | set_trip;
endmodule

// File: rtl/leg_gate_conditioner.sv
module leg_gate_conditioner #(
   parameter int unsigned DEL_W = gpc_pkg::GPC_DEL_W_DEF,
   parameter int unsigned DLY_W = gpc_pkg::GPC_DLY_W_DEF,
   parameter int unsigned SYNC  = gpc_pkg::GPC_SYNC_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             pwm_raw,
   input  logic [DEL_W-1:0] del_code,
   input  logic [DLY_W-1:0] dly_code,
   input  logic             drive_enable,
   input  logic             set_trip,
   output logic             gate_hi,
   output logic             gate_lo,
   output logic             trip_ok
);
   localparam int unsigned N_SW = 2;

   if (DEL_W < 2 || DEL_W > 16) begin : g_bad_del
      $error("DEL_W out of range");
   end
   if (DLY_W < 2 || DLY_W > 16) begin : g_bad_dly
      $error("DLY_W out of range");
   end
   if (SYNC < 2 || SYNC > 4) begin : g_bad_sync
      $error("SYNC must be 2 to 4");
   end

   logic            clean_lvl;
   logic [N_SW-1:0] sw_drv;
   logic            tripped;
   logic            allow;

   gpc_min_width_filter #(.CODE_W(DEL_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .raw   (pwm_raw),
      .code  (del_code),
      .level (clean_lvl)
   );

   for (genvar gi = 0; gi < N_SW; gi++) begin : g_sw
      gpc_rise_delay #(
         .CODE_W (DLY_W),
         .SIDE   ((gi == 0) ? gpc_pkg::SW_HIGH : gpc_pkg::SW_LOW)
      ) u_dly (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (tick_en),
         .level (clean_lvl),
         .code  (dly_code),
         .drive (sw_drv[gi])
      );
   end

   gpc_trip_latch #(.SYNC(SYNC)) u_trip (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_trip (set_trip),
      .tripped  (tripped)
   );

   assign allow   = rst_n & drive_enable & ~tripped;
   assign gate_hi = sw_drv[0] & allow;
   assign gate_lo = sw_drv[1] & allow;
   assign trip_ok = ~tripped;
endmodule

// File: rtl/leg_gate_conditioner_chk.sv
module leg_gate_conditioner_chk (
   input logic clk,
   input logic rst_n,
   input logic drive_enable,
   input logic set_trip,
   input logic gate_hi,
   input logic gate_lo,
   input logic trip_ok
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!gate_hi && !gate_lo))
      else $error("R1 drive active in reset");

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo))
      else $error("R5 both drives high");

   a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> $past(!gate_lo))
      else $error("R4 upper rose while lower was on");

   a_r6_inhibit_low: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_enable |-> (!gate_hi && !gate_lo))
      else $error("R6 drive active while inhibited");

   a_r7_trip_forces: assert property (@(posedge clk) disable iff (!rst_n)
      set_trip |-> (!gate_hi && !gate_lo && !trip_ok))
      else $error("R7 trip did not force outputs");

   a_r8_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip_ok && !set_trip) |=> !trip_ok)
      else $error("R8 trip latch released without reset");
endmodule

bind leg_gate_conditioner leg_gate_conditioner_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .drive_enable (drive_enable),
   .set_trip     (set_trip),
   .gate_hi      (gate_hi),
   .gate_lo      (gate_lo),
   .trip_ok      (trip_ok)
);

// File: tb/leg_gate_conditioner_tb_top.sv
`timescale 1ns/1ps
module leg_gate_conditioner_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       pwm_raw = 1'b0;
   logic [6:0] del_code = 7'd123;   // pdt = 5
   logic [5:0] dly_code = 6'd61;    // pdy = 3
   logic       drive_enable = 1'b1;
   logic       set_trip = 1'b0;
   logic       gate_hi, gate_lo, trip_ok;

   int checks = 0;
   int failures = 0;
   bit model_on = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   leg_gate_conditioner dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_raw(pwm_raw),
      .del_code(del_code), .dly_code(dly_code), .drive_enable(drive_enable),
      .set_trip(set_trip), .gate_hi(gate_hi), .gate_lo(gate_lo), .trip_ok(trip_ok)
   );

   // behavioural reference, kept in integers
   int m_lvl = 0, m_run = 0, m_hi_age = 0, m_lo_age = 0;
   int m_s1 = 0, m_s2 = 0, m_lat = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lvl = 0; m_run = 0; m_hi_age = 0; m_lo_age = 0;
         m_s1 = 0; m_s2 = 0; m_lat = 0;
      end else begin
         if (m_s2 != 0) m_lat = 1;
         m_s2 = m_s1;
         m_s1 = set_trip ? 1 : 0;
         if (tick_en) begin
            if (m_lvl != 0) begin
               m_lo_age = 0;
               if (m_hi_age < 1000) m_hi_age++;
            end else begin
               m_hi_age = 0;
               if (m_lo_age < 1000) m_lo_age++;
            end
            if ((pwm_raw ? 1 : 0) != m_lvl) begin
               m_run++;
               if (m_run >= 128 - int'(del_code)) begin
                  m_lvl = pwm_raw ? 1 : 0;
                  m_run = 0;
               end
            end else begin
               m_run = 0;
            end
         end
      end
   end

   task automatic check(string req, logic got, logic exp, string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, got, exp, $time);
      end
   endtask

   task automatic check_int(string req, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on) begin
         automatic int pdy = 64 - int'(dly_code);
         automatic bit allow = rst_n && drive_enable && !set_trip && !(m_lat != 0);
         automatic logic e_hi = allow && (m_lvl != 0) && (m_hi_age >= pdy);
         automatic logic e_lo = allow && (m_lvl == 0) && (m_lo_age >= pdy);
         automatic logic e_ok = !set_trip && !(rst_n && m_lat != 0);
         check(cur_req, gate_hi, e_hi, "model gate_hi");
         check(cur_req, gate_lo, e_lo, "model gate_lo");
         check(cur_req, trip_ok, e_ok, "model trip_ok");
         check("R5", gate_hi & gate_lo, 1'b0, "overlap");
      end
   end

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic count_win(int n, output int hi_cnt, output int lo_off);
      hi_cnt = 0;
      lo_off = 0;
      repeat (n) begin
         @(negedge clk);
         if (gate_hi) hi_cnt++;
         if (!gate_lo) lo_off++;
      end
   endtask

   task automatic pulse_test(string req, int width, int win, int exp_hi, int exp_lo_off, logic lvl);
      int h, l;
      pwm_raw = lvl;
      fork
         begin step(width); pwm_raw = ~lvl; end
         count_win(win, h, l);
      join
      check_int(req, h, exp_hi, "gate_hi high cycles");
      check_int(req, l, exp_lo_off, "gate_lo low cycles");
      step(1);
   endtask

   initial begin
      step(3);
      @(negedge clk);
      check("R1", gate_hi, 1'b0, "hi in reset");
      check("R1", gate_lo, 1'b0, "lo in reset");
      check("R1", trip_ok, 1'b1, "trip_ok in reset");
      model_on = 1;
      step(1);
      rst_n = 1;
      step(15);
      @(negedge clk);
      check("R1", gate_lo, 1'b1, "lo after release");
      check("R1", gate_hi, 1'b0, "hi after release");
      step(1);

      cur_req = "R2";
      pulse_test("R2", 4, 20, 0, 0, 1'b1);      // one tick short: deleted
      cur_req = "R3";
      pulse_test("R3", 5, 30, 2, 8, 1'b1);      // exactly pdt: passes
      pulse_test("R3", 20, 40, 17, 23, 1'b1);   // width kept, minus underlap

      cur_req = "R2";
      pwm_raw = 1'b1;
      step(20);
      pulse_test("R2", 4, 20, 20, 20, 1'b0);    // low notch deleted
      pwm_raw = 1'b0;
      step(20);

      cur_req = "R4";
      dly_code = 6'd60;                         // pdy = 4
      step(2);
      pulse_test("R4", 20, 40, 16, 24, 1'b1);
      del_code = 7'd127;                        // pdt = 1
      dly_code = 6'd63;                         // pdy = 1
      step(2);
      pulse_test("R4", 2, 20, 1, 3, 1'b1);
      del_code = 7'd123;
      dly_code = 6'd61;
      step(20);

      cur_req = "R6";
      pwm_raw = 1'b1;
      step(20);
      drive_enable = 1'b0;
      @(negedge clk);
      check("R6", gate_hi, 1'b0, "hi inhibited");
      check("R6", gate_lo, 1'b0, "lo inhibited");
      step(5);
      drive_enable = 1'b1;
      @(negedge clk);
      check("R6", gate_hi, 1'b1, "hi resumes at once");
      step(1);
      pwm_raw = 1'b0;
      step(20);
      drive_enable = 1'b0;
      pwm_raw = 1'b1;
      step(10);
      drive_enable = 1'b1;
      @(negedge clk);
      check("R6", gate_hi, 1'b1, "state advanced while inhibited");
      step(1);
      pwm_raw = 1'b0;
      step(20);

      cur_req = "R7";
      set_trip = 1'b1;
      @(negedge clk);
      check("R7", gate_lo, 1'b0, "lo on trip");
      check("R7", trip_ok, 1'b0, "trip_ok on trip");
      step(4);
      cur_req = "R8";
      set_trip = 1'b0;
      step(5);
      @(negedge clk);
      check("R8", trip_ok, 1'b0, "trip held");
      check("R8", gate_lo, 1'b0, "lo held off");
      step(1);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", trip_ok, 1'b1, "reset clears trip");
      step(15);
      set_trip = 1'b1;
      step(3);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", trip_ok, 1'b0, "trip input high at release");
      step(4);
      set_trip = 1'b0;
      step(3);
      @(negedge clk);
      check("R8", trip_ok, 1'b0, "relatched after release");
      step(1);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(15);

      cur_req = "R9";
      begin
         int h, l;
         tick_en = 1'b0;
         pwm_raw = 1'b1;
         count_win(30, h, l);
         check_int("R9", h, 0, "hi with tick held low");
         check_int("R9", l, 0, "lo off cycles with tick held low");
         step(1);
         pwm_raw = 1'b0;
         step(1);
         fork
            begin repeat (16) begin step(1); tick_en = ~tick_en; end end
            begin pwm_raw = 1'b1; step(8); pwm_raw = 1'b0; end
            count_win(16, h, l);
         join
         check_int("R9", h, 0, "four ticks of eight cycles deleted");
         tick_en = 1'b1;
         step(10);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule